// File: doc/BRIEF.md
# Console Run/Halt/Step Controller

This block decides when the processor runs, stops or advances by one step, under the control of the operator's console. It watches two level switches: a run-enable switch (enable or halt) and a step-granularity switch (one instruction or one bus cycle). It also watches two momentary keys, the start key and the continue key, which it samples as synchronous levels and reduces to press and release events. The processor reports instruction boundaries and bus-cycle boundaries through single-cycle strobes. The controller answers with a run flag, a system-initialise level, a start-address strobe with its address, and a service flag. The service flag tells the examine/deposit logic that the machine is parked at an instruction boundary.

Holding the start key keeps the system in initialisation. When the key is let go, the machine begins running only if the run-enable switch is on. The start address is the last address loaded from the switches, provided no examine or deposit has happened since that load. Otherwise the current bus address is used. With the run-enable switch off, the processor stops at the next boundary of the selected kind. Each press of the continue key then grants exactly one step. With the switch on, a continue press resumes free running without initialisation.

Top module: `panel_run_ctrl`

## Requirements
- R1: After reset, runOut is 0, serviceOut is 1, sysInit is 0 and startLoad is 0.
- R2: One cycle after a rising edge of startKey, sysInit is 1 and runOut is 0. Both stay so for as long as startKey is held.
- R3: If enableSel is 1 (enable) when startKey falls, then one cycle later sysInit is 0, runOut is 1 and startLoad is 1. startLoad returns to 0 on the following cycle.
- R4: If enableSel is 0 (halt) when startKey falls, then one cycle later sysInit is 0, runOut stays 0, startLoad stays 0 and serviceOut is 1.
- R5: The startAddr presented with startLoad equals the switchAddr captured at the last loadAddrPulse, provided no examPulse or depPulse has occurred since that load. Otherwise it equals busAddr at the cycle startKey falls.
- R6: When running with enableSel 0 and stepInstr 1 (instruction mode), a cycleDone alone does not stop the processor. An instrDone makes runOut 0 and serviceOut 1 one cycle later.
- R7: When running with enableSel 0 and stepInstr 0 (cycle mode), a cycleDone makes runOut 0 one cycle later. serviceOut is then 0, unless instrDone is also 1 in the same cycle, in which case serviceOut is 1.
- R8: When halted with enableSel 0, a rising edge of contKey sets runOut to 1 for exactly one step of the selected kind, after which runOut returns to 0. Holding contKey longer grants no further step.
- R9: When halted with enableSel 1, a rising edge of contKey sets runOut to 1 without asserting sysInit. Running then continues across instrDone and cycleDone strobes.
- R10: serviceOut and runOut are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enableSel | input | 1 | Run-enable switch: 1 = enable, 0 = halt |
| stepInstr | input | 1 | Step granularity: 1 = instruction, 0 = bus cycle |
| startKey | input | 1 | Start key level |
| contKey | input | 1 | Continue key level |
| loadAddrPulse | input | 1 | Load-address key operation, one cycle |
| examPulse | input | 1 | Examine key operation, one cycle |
| depPulse | input | 1 | Deposit key operation, one cycle |
| switchAddr | input | ADDR_W | Switch register value |
| busAddr | input | ADDR_W | Current bus address register value |
| instrDone | input | 1 | Processor instruction-boundary strobe |
| cycleDone | input | 1 | Processor bus-cycle-boundary strobe |
| runOut | output | 1 | Processor run enable and run lamp |
| sysInit | output | 1 | System initialise, held while start is down |
| serviceOut | output | 1 | Halted at an instruction boundary; examine/deposit allowed |
| startLoad | output | 1 | One-cycle strobe: load startAddr into the program counter |
| startAddr | output | ADDR_W | Address to start execution at |

## Verification
The bench builds the block with the default ADDR_W of 18. At this width, all-ones switch settings and addresses above 16 bits can be used to tell the saved load address apart from the live bus address. The table drives every combination of switch setting and boundary strobe that matters for halting from the running state. It includes the cycle-mode case where the instruction and bus-cycle boundaries coincide. Directed sequences hold keys for several cycles to show that one press yields one step. They also show that an examine or a deposit after a load redirects the start address.

// File: rtl/panel_run_pkg.sv
package panel_run_pkg;

  typedef enum logic [2:0] {
    S_SVC  = 3'd0,  // halted at instruction boundary
    S_CYC  = 3'd1,  // halted after a single bus cycle
    S_INIT = 3'd2,  // start held: system initialise
    S_RUN  = 3'd3,  // free running
    S_STEP = 3'd4   // one granted step
  } runState_e;

  typedef struct packed {
    logic latchStart;  // capture start address, pulse start strobe
  } ctrlStrobe_t;

endpackage

// File: rtl/panel_run_fsm.sv
module panel_run_fsm
  import panel_run_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enableSel,
  input  logic        stepInstr,
  input  logic        startKey,
  input  logic        contKey,
  input  logic        instrDone,
  input  logic        cycleDone,
  output logic        runOut,
  output logic        sysInit,
  output logic        serviceOut,
  output ctrlStrobe_t strobes
);

  runState_e state, stateNext;
  logic startQ, contQ, runQ, svcQ;
  logic startPress, startRel, contPress, haltNow;
  runState_e haltTarget;

  // key edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startQ <= 1'b0;
      contQ  <= 1'b0;
    end else begin
      startQ <= startKey;
      contQ  <= contKey;
    end
  end

  assign startPress = startKey & ~startQ;
  assign startRel   = ~startKey & startQ;
  assign contPress  = contKey & ~contQ;

  // halt point: instruction boundary always qualifies, bus cycle only in cycle mode
  assign haltNow    = instrDone | (cycleDone & ~stepInstr);
  assign haltTarget = instrDone ? S_SVC : S_CYC;

  always_comb begin
    stateNext = state;
    if (startPress) begin
      stateNext = S_INIT;
    end else begin
      unique case (state)
        S_SVC, S_CYC: if (contPress) stateNext = enableSel ? S_RUN : S_STEP;
        S_INIT:       if (startRel)  stateNext = enableSel ? S_RUN : S_SVC;
        S_RUN:        if (!enableSel && haltNow) stateNext = haltTarget;
        S_STEP:       if (haltNow) stateNext = haltTarget;
        default:      stateNext = S_SVC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_SVC;
      runQ  <= 1'b0;
      svcQ  <= 1'b1;
    end else begin
      state <= stateNext;
      runQ  <= (stateNext == S_RUN) || (stateNext == S_STEP);
      svcQ  <= (stateNext == S_SVC);
    end
  end

  assign runOut             = runQ;
  assign serviceOut         = svcQ;
  assign sysInit            = (state == S_INIT);
  assign strobes.latchStart = (state == S_INIT) && startRel && enableSel;

  assert_svc_not_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    svcQ |-> !runQ);

  assert_init_no_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INIT) |-> !runQ);

  assert_instr_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && !startPress && !enableSel && stepInstr && instrDone) |=> (!runQ && svcQ));

  assert_cycle_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && !startPress && !enableSel && !stepInstr && cycleDone && !instrDone)
      |=> (!runQ && !svcQ));

  assert_step_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!runQ && contKey && contQ && !startKey && !startQ) |=> !runQ);

endmodule

// File: rtl/panel_run_addr.sv
module panel_run_addr
  import panel_run_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobes,
  input  logic              loadAddrPulse,
  input  logic              examPulse,
  input  logic              depPulse,
  input  logic [ADDR_W-1:0] switchAddr,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] startAddr,
  output logic              startLoad
);

  logic [ADDR_W-1:0] savedAddr;
  logic              freshQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      savedAddr <= '0;
      freshQ    <= 1'b0;
      startAddr <= '0;
      startLoad <= 1'b0;
    end else begin
      if (loadAddrPulse) begin
        savedAddr <= switchAddr;
        freshQ    <= 1'b1;
      end else if (examPulse || depPulse) begin
        freshQ    <= 1'b0;
      end
      startLoad <= strobes.latchStart;
      if (strobes.latchStart) startAddr <= freshQ ? savedAddr : busAddr;
    end
  end

  assert_load_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    startLoad |=> !startLoad);

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.latchStart |=> $stable(startAddr));

endmodule

// File: rtl/panel_run_ctrl.sv
module panel_run_ctrl
  import panel_run_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enableSel,
  input  logic              stepInstr,
  input  logic              startKey,
  input  logic              contKey,
  input  logic              loadAddrPulse,
  input  logic              examPulse,
  input  logic              depPulse,
  input  logic [ADDR_W-1:0] switchAddr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              instrDone,
  input  logic              cycleDone,
  output logic              runOut,
  output logic              sysInit,
  output logic              serviceOut,
  output logic              startLoad,
  output logic [ADDR_W-1:0] startAddr
);

  ctrlStrobe_t strobes;

  panel_run_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enableSel  (enableSel),
    .stepInstr  (stepInstr),
    .startKey   (startKey),
    .contKey    (contKey),
    .instrDone  (instrDone),
    .cycleDone  (cycleDone),
    .runOut     (runOut),
    .sysInit    (sysInit),
    .serviceOut (serviceOut),
    .strobes    (strobes)
  );

  panel_run_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobes       (strobes),
    .loadAddrPulse (loadAddrPulse),
    .examPulse     (examPulse),
    .depPulse      (depPulse),
    .switchAddr    (switchAddr),
    .busAddr       (busAddr),
    .startAddr     (startAddr),
    .startLoad     (startLoad)
  );

endmodule

// File: tb/panel_run_ctrl_bench.sv
`timescale 1ns/1ps
module panel_run_ctrl_bench;

  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enableSel = 1'b0, stepInstr = 1'b1, startKey = 1'b0, contKey = 1'b0;
  logic loadAddrPulse = 1'b0, examPulse = 1'b0, depPulse = 1'b0;
  logic [AW-1:0] switchAddr = '0, busAddr = '0;
  logic instrDone = 1'b0, cycleDone = 1'b0;
  logic runOut, sysInit, serviceOut, startLoad;
  logic [AW-1:0] startAddr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  panel_run_ctrl #(.ADDR_W(AW)) u_panel_run_ctrl (
    .clk(clk), .rst_n(rst_n), .enableSel(enableSel), .stepInstr(stepInstr),
    .startKey(startKey), .contKey(contKey), .loadAddrPulse(loadAddrPulse),
    .examPulse(examPulse), .depPulse(depPulse), .switchAddr(switchAddr),
    .busAddr(busAddr), .instrDone(instrDone), .cycleDone(cycleDone),
    .runOut(runOut), .sysInit(sysInit), .serviceOut(serviceOut),
    .startLoad(startLoad), .startAddr(startAddr)
  );

  // {enableSel, stepInstr, instrDone, cycleDone, expRun, expSvc}
  localparam logic [5:0] VEC [7] = '{
    6'b0_1_0_1_1_0,  // R6 cycle end ignored in instruction mode
    6'b0_1_1_1_0_1,  // R6 instruction end halts, service
    6'b0_0_0_1_0_0,  // R7 bus cycle end halts, no service
    6'b0_0_1_1_0_1,  // R7 coincident boundary gives service
    6'b1_1_1_1_1_0,  // R9 enabled keeps running
    6'b1_0_0_1_1_0,  // R9 enabled cycle mode keeps running
    6'b0_1_0_0_1_0   // R6 no boundary, keeps running
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic goRun();
    enableSel = 1'b1;
    contKey = 1'b1;
    tick();
    contKey = 1'b0;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    chk("R1 runOut", runOut, 0);
    chk("R1 serviceOut", serviceOut, 1);
    chk("R1 sysInit", sysInit, 0);
    chk("R1 startLoad", startLoad, 0);

    // table of halting behaviour from the running state
    for (int i = 0; i < 7; i++) begin
      goRun();
      chk("R9 running before vector", runOut, 1);
      enableSel = VEC[i][5];
      stepInstr = VEC[i][4];
      instrDone = VEC[i][3];
      cycleDone = VEC[i][2];
      tick();
      instrDone = 1'b0;
      cycleDone = 1'b0;
      chk("R6/R7/R9 vector runOut", runOut, VEC[i][1]);
      chk("R6/R7/R9 vector serviceOut", serviceOut, VEC[i][0]);
      chk("R10 exclusive", runOut & serviceOut, 0);
    end

    // park at an instruction boundary
    enableSel = 1'b0; stepInstr = 1'b1; instrDone = 1'b1;
    tick();
    instrDone = 1'b0;
    chk("R6 parked", serviceOut, 1);

    // R5 fresh load used; R2 init held; R3 run on release
    switchAddr = 18'h3ffff; loadAddrPulse = 1'b1;
    tick();
    loadAddrPulse = 1'b0; switchAddr = 18'h00005; busAddr = 18'h00abc;
    enableSel = 1'b1; startKey = 1'b1;
    tick();
    chk("R2 sysInit on press", sysInit, 1);
    chk("R2 runOut during init", runOut, 0);
    repeat (3) tick();
    chk("R2 sysInit still held", sysInit, 1);
    startKey = 1'b0;
    tick();
    chk("R3 sysInit dropped", sysInit, 0);
    chk("R3 runOut", runOut, 1);
    chk("R3 startLoad", startLoad, 1);
    chk("R5 fresh address", startAddr, 18'h3ffff);
    tick();
    chk("R3 startLoad single", startLoad, 0);

    // R5 examine after load redirects to bus address
    switchAddr = 18'h12345; loadAddrPulse = 1'b1;
    tick();
    loadAddrPulse = 1'b0; examPulse = 1'b1;
    tick();
    examPulse = 1'b0; busAddr = 18'h20100; startKey = 1'b1;
    tick();
    startKey = 1'b0;
    tick();
    chk("R5 stale after exam", startAddr, 18'h20100);

    // R5 deposit after load also redirects
    switchAddr = 18'h00042; loadAddrPulse = 1'b1;
    tick();
    loadAddrPulse = 1'b0; depPulse = 1'b1;
    tick();
    depPulse = 1'b0; busAddr = 18'h10001; startKey = 1'b1;
    tick();
    startKey = 1'b0;
    tick();
    chk("R5 stale after deposit", startAddr, 18'h10001);

    // R4 start with halt selected only initialises
    enableSel = 1'b0; startKey = 1'b1;
    tick();
    chk("R4 sysInit", sysInit, 1);
    startKey = 1'b0;
    tick();
    chk("R4 runOut", runOut, 0);
    chk("R4 startLoad", startLoad, 0);
    chk("R4 sysInit cleared", sysInit, 0);
    chk("R4 serviceOut", serviceOut, 1);

    // R8 single instruction step, key held
    stepInstr = 1'b1; contKey = 1'b1;
    tick();
    chk("R8 step granted", runOut, 1);
    chk("R8 no service while stepping", serviceOut, 0);
    cycleDone = 1'b1;
    tick();
    cycleDone = 1'b0;
    chk("R8 cycle end ignored", runOut, 1);
    instrDone = 1'b1; cycleDone = 1'b1;
    tick();
    instrDone = 1'b0; cycleDone = 1'b0;
    chk("R8 halted after instruction", runOut, 0);
    chk("R8 service after instruction", serviceOut, 1);
    repeat (3) tick();
    chk("R8 held key grants nothing", runOut, 0);
    contKey = 1'b0;
    tick();

    // R8 single bus cycle step
    stepInstr = 1'b0; contKey = 1'b1;
    tick();
    contKey = 1'b0;
    chk("R8 cycle step granted", runOut, 1);
    cycleDone = 1'b1;
    tick();
    cycleDone = 1'b0;
    chk("R8 halted after cycle", runOut, 0);
    chk("R7 no service after cycle", serviceOut, 0);

    // R9 continue with enable resumes without init
    enableSel = 1'b1; contKey = 1'b1;
    tick();
    contKey = 1'b0;
    chk("R9 resumed", runOut, 1);
    chk("R9 no init", sysInit, 0);
    instrDone = 1'b1; cycleDone = 1'b1;
    tick();
    instrDone = 1'b0; cycleDone = 1'b0;
    chk("R9 keeps running", runOut, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule